// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block drives the single interrupt line that a block-oriented storage device presents to its host processor. Three internal event strobes can raise the request: completion of a device operation, a read data block waiting to go to the host, and room for another write data block. Once raised, an internal pending flag holds the request until the host touches one of three registers in a way that acknowledges it, and each acknowledgement is qualified by the device's busy (BSY) and data-request (DRQ) status bits at the moment of the access.

Host register accesses arrive already decoded, as one-cycle strobes: a status register read, a command register write, and a device control register write that carries its data byte. In the control byte, bit 2 is the soft-reset request and bit 1 is the interrupt disable. The disable masks only the pin; the pending flag keeps its value underneath. The pin polarity is selected by a static configuration input, and after reset the pin sits at its inactive level.

Write transfers deliver their first data block without an interrupt, because the host has just issued the command and is already waiting to send it. A small saturating block counter, cleared by every command register write, tells the first write block apart from the rest.

Top module: `hirq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no event, the pin irq_out is at its inactive level (0 when cfg_active_low is 0, 1 when it is 1), and the interrupt disable is off.
- R2: An ev_op_done strobe sets the pending flag; with the disable off, irq_out is at its active level from the cycle after the strobe.
- R3: Every ev_rd_blk strobe sets the pending flag, including after an earlier flag was cleared.
- R4: The first ev_wr_blk strobe after reset or after a host_cmd_wr strobe leaves the flag unchanged; every later ev_wr_blk strobe sets it.
- R5: A host_stat_rd strobe clears the flag when bsy is 0 and has no effect when bsy is 1.
- R6: A host_cmd_wr strobe clears the flag only when bsy and drq are both 0; with either at 1 the flag stays set.
- R7: A host_ctl_wr strobe with bit 2 of host_ctl_wdata at 1 clears the flag whatever bsy and drq are.
- R8: When an event strobe and a clearing access fall in the same cycle, the flag ends that cycle set.
- R9: Each host_ctl_wr loads the disable from bit 1 of host_ctl_wdata; while it is 1, irq_out is at its inactive level, and the pending flag is kept, so clearing the disable with the flag still set drives irq_out active again.
- R10: With cfg_active_low at 1, the active level of irq_out is 0 and the inactive level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_op_done | input | 1 | Strobe: device operation finished |
| ev_rd_blk | input | 1 | Strobe: read block ready for the host |
| ev_wr_blk | input | 1 | Strobe: device can take a write block |
| host_stat_rd | input | 1 | Strobe: host read of the status register |
| host_cmd_wr | input | 1 | Strobe: host write of the command register |
| host_ctl_wr | input | 1 | Strobe: host write of the device control register |
| host_ctl_wdata | input | 8 | Data written to the device control register (bit 2 soft reset, bit 1 disable) |
| bsy | input | 1 | Current busy status bit |
| drq | input | 1 | Current data-request status bit |
| cfg_active_low | input | 1 | 1 selects an active-low pin |
| irq_out | output | 1 | Interrupt request pin toward the host |

## Verification
A sequence of single-cycle vectors alternates raising events with each acknowledging access under every relevant BSY and DRQ combination, so a clear that ignores its qualifier, or one that is missing, shows as a wrong pin level the next cycle. Write-block strobes follow a command write so that a missing or doubled first-block suppression is told apart from the ordinary set. Same-cycle event and clear pairs separate the event-wins priority from the opposite ordering, and a disable, hold and enable pattern shows whether the mask touched the pending flag. Directed steps then repeat set and clear with the inverted polarity and apply reset with a request pending.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

   // decoded clearing causes, one bit per host access kind
   typedef struct packed {
      logic stat_rd;
      logic cmd_wr;
      logic srst;
   } hirq_clr_t;

   localparam int unsigned HIRQ_CTL_W = 8;

endpackage

// File: rtl/hirq_evt.sv
module hirq_evt #(
   parameter int unsigned CNT_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_op_done,
   input  logic ev_rd_blk,
   input  logic ev_wr_blk,
   input  logic cmd_start,
   output logic set_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      assert (CNT_W >= 1) else $error("hirq_evt: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] blk_cnt_q;
   logic             first_blk;

   assign first_blk = (blk_cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_cnt_q <= '0;
      end else if (cmd_start) begin
         blk_cnt_q <= '0;
      end else if (ev_wr_blk && (blk_cnt_q != CNT_MAX)) begin
         blk_cnt_q <= blk_cnt_q + 1'b1;
      end
   end

   assign set_o = ev_op_done | ev_rd_blk | (ev_wr_blk & ~first_blk);

endmodule

// File: rtl/hirq_clr.sv
module hirq_clr
   import hirq_pkg::*;
#(
   parameter int unsigned SRST_BIT = 2,
   parameter int unsigned NIEN_BIT = 1
) (
   input  logic                  host_stat_rd,
   input  logic                  host_cmd_wr,
   input  logic                  host_ctl_wr,
   input  logic [HIRQ_CTL_W-1:0] host_ctl_wdata,
   input  logic                  bsy,
   input  logic                  drq,
   output logic                  clr_o,
   output logic                  mask_we,
   output logic                  mask_d
);

   initial begin
      assert (SRST_BIT < HIRQ_CTL_W && NIEN_BIT < HIRQ_CTL_W)
         else $error("hirq_clr: control bit index out of range");
      assert (SRST_BIT != NIEN_BIT)
         else $error("hirq_clr: control bits must differ");
   end

   hirq_clr_t cause;
   logic      unused_ctl;

   always_comb begin
      cause.stat_rd = host_stat_rd & ~bsy;
      cause.cmd_wr  = host_cmd_wr & ~bsy & ~drq;
      cause.srst    = host_ctl_wr & host_ctl_wdata[SRST_BIT];
   end

   assign clr_o      = |cause;
   assign mask_we    = host_ctl_wr;
   assign mask_d     = host_ctl_wdata[NIEN_BIT];
   assign unused_ctl = ^host_ctl_wdata;

endmodule

// File: rtl/hirq_flag.sv
module hirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_we,
   input  logic mask_d,
   output logic pend_q,
   output logic mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (set_i) begin
         pend_q <= 1'b1;
      end else if (clr_i) begin
         pend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b0;
      end else if (mask_we) begin
         mask_q <= mask_d;
      end
   end

endmodule

// File: rtl/hirq_drv.sv
module hirq_drv #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic mask_i,
   input  logic active_low,
   output logic irq_o
);

   logic req;

   assign req = pend_i & ~mask_i;

   generate
      if (OUT_REG) begin : g_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= 1'b0;
            end else begin
               req_q <= req;
            end
         end
         assign irq_o = req_q ^ active_low;
      end else begin : g_comb
         assign irq_o = req ^ active_low;
      end
   endgenerate

endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
   import hirq_pkg::*;
#(
   parameter int unsigned CNT_W    = 2,
   parameter int unsigned SRST_BIT = 2,
   parameter int unsigned NIEN_BIT = 1,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ev_op_done,
   input  logic                  ev_rd_blk,
   input  logic                  ev_wr_blk,
   input  logic                  host_stat_rd,
   input  logic                  host_cmd_wr,
   input  logic                  host_ctl_wr,
   input  logic [HIRQ_CTL_W-1:0] host_ctl_wdata,
   input  logic                  bsy,
   input  logic                  drq,
   input  logic                  cfg_active_low,
   output logic                  irq_out
);

   logic set_s;
   logic clr_s;
   logic mask_we_s;
   logic mask_d_s;
   logic pend_q;
   logic mask_q;

   hirq_evt #(.CNT_W(CNT_W)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_op_done (ev_op_done),
      .ev_rd_blk  (ev_rd_blk),
      .ev_wr_blk  (ev_wr_blk),
      .cmd_start  (host_cmd_wr),
      .set_o      (set_s)
   );

   hirq_clr #(.SRST_BIT(SRST_BIT), .NIEN_BIT(NIEN_BIT)) u_clr (
      .host_stat_rd   (host_stat_rd),
      .host_cmd_wr    (host_cmd_wr),
      .host_ctl_wr    (host_ctl_wr),
      .host_ctl_wdata (host_ctl_wdata),
      .bsy            (bsy),
      .drq            (drq),
      .clr_o          (clr_s),
      .mask_we        (mask_we_s),
      .mask_d         (mask_d_s)
   );

   hirq_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_s),
      .clr_i   (clr_s),
      .mask_we (mask_we_s),
      .mask_d  (mask_d_s),
      .pend_q  (pend_q),
      .mask_q  (mask_q)
   );

   hirq_drv #(.OUT_REG(OUT_REG)) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_q),
      .mask_i     (mask_q),
      .active_low (cfg_active_low),
      .irq_o      (irq_out)
   );

endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk
   import hirq_pkg::*;
#(
   parameter int unsigned SRST_BIT = 2,
   parameter bit          OUT_REG  = 1'b0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ev_op_done,
   input logic                  ev_rd_blk,
   input logic                  ev_wr_blk,
   input logic                  host_stat_rd,
   input logic                  host_cmd_wr,
   input logic                  host_ctl_wr,
   input logic [HIRQ_CTL_W-1:0] host_ctl_wdata,
   input logic                  bsy,
   input logic                  drq,
   input logic                  cfg_active_low,
   input logic                  irq_out,
   input logic                  pend_q,
   input logic                  mask_q
);

   logic no_ev;
   assign no_ev = !ev_op_done && !ev_rd_blk && !ev_wr_blk;

   // R2
   op_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_op_done |=> pend_q);

   // R3
   rd_blk_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd_blk |=> pend_q);

   // R5
   busy_stat_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && host_stat_rd && bsy && !host_cmd_wr && !host_ctl_wr) |=> pend_q);

   // R6
   cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cmd_wr && !bsy && !drq && no_ev) |=> !pend_q);

   // R7
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ctl_wr && host_ctl_wdata[SRST_BIT] && no_ev) |=> !pend_q);

   generate
      if (!OUT_REG) begin : g_pin
         // R9
         mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q |-> (irq_out == cfg_active_low));
      end
   endgenerate

endmodule

bind hirq_ctrl hirq_ctrl_chk #(.SRST_BIT(SRST_BIT), .OUT_REG(OUT_REG)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ev_op_done     (ev_op_done),
   .ev_rd_blk      (ev_rd_blk),
   .ev_wr_blk      (ev_wr_blk),
   .host_stat_rd   (host_stat_rd),
   .host_cmd_wr    (host_cmd_wr),
   .host_ctl_wr    (host_ctl_wr),
   .host_ctl_wdata (host_ctl_wdata),
   .bsy            (bsy),
   .drq            (drq),
   .cfg_active_low (cfg_active_low),
   .irq_out        (irq_out),
   .pend_q         (pend_q),
   .mask_q         (mask_q)
);

// File: tb/hirq_ctrl_bench.sv
module hirq_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_op_done = 1'b0, ev_rd_blk = 1'b0, ev_wr_blk = 1'b0;
   logic       host_stat_rd = 1'b0, host_cmd_wr = 1'b0, host_ctl_wr = 1'b0;
   logic [7:0] host_ctl_wdata = 8'h00;
   logic       bsy = 1'b0, drq = 1'b0;
   logic       cfg_active_low = 1'b0;
   logic       irq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   hirq_ctrl u_hirq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ev_op_done(ev_op_done), .ev_rd_blk(ev_rd_blk), .ev_wr_blk(ev_wr_blk),
      .host_stat_rd(host_stat_rd), .host_cmd_wr(host_cmd_wr),
      .host_ctl_wr(host_ctl_wr), .host_ctl_wdata(host_ctl_wdata),
      .bsy(bsy), .drq(drq), .cfg_active_low(cfg_active_low),
      .irq_out(irq_out)
   );

   // row: op rd wr srd cwr ctw srst nien bsy drq exp(active-high pin)
   localparam int NV = 18;
   localparam logic [10:0] VEC [NV] = '{
      11'b1_0_0_0_0_0_0_0_0_0_1,  // R2 op done raises
      11'b0_0_0_1_0_0_0_0_1_0_1,  // R5 status read while busy: kept
      11'b0_0_0_1_0_0_0_0_0_0_0,  // R5 status read idle: clear
      11'b0_1_0_0_0_0_0_0_0_0_1,  // R3 read block raises
      11'b0_0_0_0_1_0_0_0_0_1_1,  // R6 command write with drq: kept
      11'b0_0_0_0_1_0_0_0_1_0_1,  // R6 command write with bsy: kept
      11'b0_0_0_0_1_0_0_0_0_0_0,  // R6 command write idle: clear
      11'b0_0_1_0_0_0_0_0_0_0_0,  // R4 first write block: suppressed
      11'b0_0_1_0_0_0_0_0_0_0_1,  // R4 second write block raises
      11'b0_0_0_1_0_0_0_0_0_0_0,  // R5 clear
      11'b0_0_1_0_0_0_0_0_0_0_1,  // R4 third write block raises
      11'b0_0_0_0_0_1_1_0_1_1_0,  // R7 soft reset clears despite bsy/drq
      11'b1_0_0_1_0_0_0_0_0_0_1,  // R8 op done with status clear
      11'b0_1_0_0_0_1_1_0_0_0_1,  // R8 read block with soft reset
      11'b0_0_0_0_0_1_0_1_0_0_0,  // R9 disable masks pin
      11'b0_0_0_0_0_0_0_0_0_0_0,  // R9 still masked
      11'b0_0_0_0_0_1_0_0_0_0_1,  // R9 enable: pending kept
      11'b0_0_0_0_0_1_1_0_0_0_0   // R7 soft reset clears
   };

   task automatic idle_inputs();
      ev_op_done = 0; ev_rd_blk = 0; ev_wr_blk = 0;
      host_stat_rd = 0; host_cmd_wr = 0; host_ctl_wr = 0;
      host_ctl_wdata = 8'h00; bsy = 0; drq = 0;
   endtask

   task automatic check(input logic exp, input string req);
      n_cmp++;
      if (irq_out !== exp) begin
         n_bad++;
         $display("FAIL %s: irq_out=%b expected %b", req, irq_out, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_inputs();
   endtask

   initial begin
      idle_inputs();
      #1;
      check(1'b0, "R1 in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b0, "R1 after reset");

      for (int i = 0; i < NV; i++) begin
         ev_op_done        = VEC[i][10];
         ev_rd_blk         = VEC[i][9];
         ev_wr_blk         = VEC[i][8];
         host_stat_rd      = VEC[i][7];
         host_cmd_wr       = VEC[i][6];
         host_ctl_wr       = VEC[i][5];
         host_ctl_wdata[2] = VEC[i][4];
         host_ctl_wdata[1] = VEC[i][3];
         bsy               = VEC[i][2];
         drq               = VEC[i][1];
         step();
         check(VEC[i][0], $sformatf("vector %0d", i));
      end

      // R10 inverted polarity
      cfg_active_low = 1'b1;
      #1 check(1'b1, "R10 inactive high");
      @(negedge clk);
      ev_op_done = 1; step();
      check(1'b0, "R10 active low");
      host_ctl_wr = 1; host_ctl_wdata = 8'h04; step();
      check(1'b1, "R10 cleared high");

      // R1 reset with a request pending
      ev_rd_blk = 1; step();
      check(1'b0, "R1 pending before reset");
      rst_n = 1'b0;
      #1 check(1'b1, "R1 reset forces inactive");
      @(negedge clk);
      rst_n = 1'b1;
      cfg_active_low = 1'b0;
      @(negedge clk);
      check(1'b0, "R1 released idle");

      // R4 first write block after reset suppressed
      ev_wr_blk = 1; step();
      check(1'b0, "R4 first after reset");
      ev_wr_blk = 1; step();
      check(1'b1, "R4 second after reset");

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: done=0 expected 1");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule